// File: doc/BRIEF.md
# Parallel-to-Serial Word Shifter with End-of-Word Marker

This block turns a parallel word into a serial bit stream on one output line. A producer holds a load strobe high while it presents the word. The word is captured on every clock edge that sees the strobe high. Once the strobe falls, the word goes out one bit per clock, most significant bit first.

A valid flag is high on every cycle that carries a data bit. A frame flag is high only on the cycle that carries the least significant bit, so a receiver can find word boundaries without counting bits. Between words the serial line and both flags are held low.

If the strobe is raised again while a word is being sent, the word in flight is dropped and the new word takes its place. The outputs are registered, so the line is free of glitches.

Top module: `p2s_shifter`

## Requirements
- R1: Every rising edge that samples load_i high copies data_i into the shifter. When load_i is held high for several cycles, the word present at the last such edge is the one sent.
- R2: The first serial bit, with valid_o high, appears right after the first rising edge that samples load_i low following a load. No bit is sent while load_i is high.
- R3: Bits go out most significant bit first. Serial cycle j (j = 0 .. W-1) carries bit W-1-j of the captured word on ser_o.
- R4: valid_o is high for exactly W consecutive cycles per word, and only on cycles that carry a data bit.
- R5: frame_o is high only on the cycle that carries bit 0 (the last bit), and valid_o is high on that cycle. On the next cycle valid_o is low.
- R6: After the last bit, ser_o, valid_o and frame_o stay 0 until the next load.
- R7: Raising load_i during a transmission aborts it. ser_o, valid_o and frame_o are 0 on each cycle after an edge that samples load_i high. The new word is then sent in full.
- R8: While rst_ni is low, ser_o, valid_o and frame_o are 0 and the bit counter is cleared. After reset is released, nothing is sent until a load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| load_i | input | 1 | Capture strobe; sending starts after it falls |
| data_i | input | W | Parallel word |
| ser_o | output | 1 | Serial data bit |
| valid_o | output | 1 | High while ser_o carries a data bit |
| frame_o | output | 1 | High on the last (LSB) bit of a word |

## Verification
Every output is registered. The flags and bit seen after an edge follow from the inputs sampled at that edge. The bench drives inputs on falling edges and samples on the next falling edge, so each sample lands one half-period after the edge that updates the outputs.

When load_i is lowered on a falling edge, the MSB is due at the following falling edge. Bit j of the word is due j cycles after that, and the line must read idle one cycle after the LSB. While load_i is high, the zero outputs are checked one cycle after it rises.

// File: rtl/p2s_pkg.sv
package p2s_pkg;
  function automatic int cnt_bits(input int width);
    return $clog2(width + 1);
  endfunction
endpackage

// File: rtl/p2s_bit_ctr.sv
module p2s_bit_ctr
  import p2s_pkg::*;
#(
  parameter int W = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic load_i,
  input  logic step_i,
  output logic busy_o,
  output logic last_o
);
  localparam int CW = cnt_bits(W);
  localparam logic [CW-1:0] FULL = CW'(W);

  logic [CW-1:0] cnt_q;

  // bits remaining to send
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (load_i)  cnt_q <= FULL;
    else if (step_i)  cnt_q <= cnt_q - 1'b1;
  end

  assign busy_o = (cnt_q != '0);
  assign last_o = (cnt_q == CW'(1));

  AST_CNT_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= FULL); // R4
  AST_STEP_DECR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i && !load_i) |=> (cnt_q == $past(cnt_q) - 1'b1)); // R4
endmodule

// File: rtl/p2s_shift_reg.sv
module p2s_shift_reg #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic         step_i,
  input  logic [W-1:0] data_i,
  output logic         msb_o
);
  logic [W-1:0] sr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      sr_q <= '0;
    else if (load_i)  sr_q <= data_i;
    else if (step_i)  sr_q <= {sr_q[W-2:0], 1'b0};
  end

  assign msb_o = sr_q[W-1];

  AST_LOAD_CAPT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> (sr_q == $past(data_i))); // R1
endmodule

// File: rtl/p2s_shifter.sv
module p2s_shifter #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] data_i,
  output logic         ser_o,
  output logic         valid_o,
  output logic         frame_o
);
  logic busy, last, msb, step;

  assign step = busy && !load_i;

  p2s_bit_ctr #(.W(W)) u_ctr (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .load_i(load_i),
    .step_i(step),
    .busy_o(busy),
    .last_o(last)
  );

  p2s_shift_reg #(.W(W)) u_sr (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .load_i(load_i),
    .step_i(step),
    .data_i(data_i),
    .msb_o (msb)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ser_o   <= 1'b0;
      valid_o <= 1'b0;
      frame_o <= 1'b0;
    end else begin
      ser_o   <= step & msb;
      valid_o <= step;
      frame_o <= step & last;
    end
  end

  AST_LOAD_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> (!valid_o && !frame_o && !ser_o)); // R7
  AST_START_NEXT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && $past(load_i)) |=> valid_o); // R2
  AST_FRAME_VALID: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_o |-> valid_o); // R5
  AST_FRAME_END: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_o |=> !valid_o); // R5
  AST_IDLE_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_o |-> !ser_o); // R6
endmodule

// File: tb/sim_p2s_shifter.sv
`timescale 1ns/1ps
module sim_p2s_shifter;
  localparam int W = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic load = 1'b0;
  logic [W-1:0] data = '0;
  logic ser, valid, frame;
  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  p2s_shifter #(.W(W)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .load_i(load), .data_i(data),
    .ser_o(ser), .valid_o(valid), .frame_o(frame)
  );

  function automatic logic [2:0] exp_bit(input logic [W-1:0] w, input int j);
    return {w[W-1-j], 1'b1, (j == W-1)};
  endfunction

  task automatic chk(input string req, input logic [2:0] exp);
    n_chk++;
    if ({ser, valid, frame} !== exp) begin
      n_bad++;
      $display("FAIL %s: {ser,valid,frame} actual=%b expected=%b t=%0t",
               req, {ser, valid, frame}, exp, $time);
    end
  endtask

  // hold load for 'hold' cycles, presenting w on the last one
  task automatic do_load(input logic [W-1:0] w, input int hold);
    for (int h = 0; h < hold; h++) begin
      load = 1'b1;
      data = (h == hold - 1) ? w : W'($urandom);
      @(negedge clk);
      chk("R7 load quiet", 3'b000);
    end
    load = 1'b0;
    data = W'($urandom);
  endtask

  task automatic send_check(input logic [W-1:0] w, input int upto);
    for (int j = 0; j < upto; j++) begin
      @(negedge clk);
      if (j == 0) chk("R2 start", exp_bit(w, j));
      else if (j == W-1) chk("R5 frame on LSB", exp_bit(w, j));
      else chk("R3 R4 bit order", exp_bit(w, j));
    end
  endtask

  task automatic idle_check(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      chk("R6 idle", 3'b000);
    end
  endtask

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    chk("R8 reset low", 3'b000);
    rst_n = 1'b1;
    idle_check(3); // R8 nothing sent after reset

    // directed: single-cycle load
    do_load(8'hA5, 1);
    send_check(8'hA5, W);
    idle_check(2);
    // directed: long hold, last word wins (R1)
    do_load(8'h81, 4);
    send_check(8'h81, W);
    idle_check(1);
    // directed: all ones, back to back load
    do_load(8'hFF, 1);
    send_check(8'hFF, W);
    do_load(8'h01, 2);
    send_check(8'h01, W);
    idle_check(1);
    // directed: abort mid word (R7)
    do_load(8'hC3, 1);
    send_check(8'hC3, 3);
    do_load(8'h5A, 1);
    send_check(8'h5A, W);
    idle_check(1);
    // directed: reset mid word (R8)
    do_load(8'h7E, 1);
    send_check(8'h7E, 4);
    rst_n = 1'b0;
    #1;
    chk("R8 async reset", 3'b000);
    @(negedge clk);
    rst_n = 1'b1;
    idle_check(W + 2);

    // random
    for (int r = 0; r < 60; r++) begin
      logic [W-1:0] w;
      int hold, gap, cut;
      w = W'($urandom);
      hold = 1 + int'($urandom % 3);
      gap = int'($urandom % 3);
      cut = (($urandom % 4) == 0) ? 1 + int'($urandom % (W-1)) : W;
      do_load(w, hold);
      send_check(w, cut);
      if (cut == W) idle_check(gap);
    end
    idle_check(2);
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    #(5.0 * 200000);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end
endmodule